// File: doc/BRIEF.md
# Return-Address Prediction Stack with Link-Register Hints

This block sits beside an RV32 instruction-fetch path and predicts where procedure returns will go. Each valid cycle it looks at one 32-bit instruction word and its PC. For the two jump-and-link forms it reads the destination and base register numbers. Registers 1 and 5 are treated as link registers. From them it chooses one of four stack actions: no action, save a return address, take one back, or take one back and save a new one in the same step.

Saved addresses are the instruction PC plus 4. They live in a small circular buffer. When the buffer is full, a new save replaces the oldest entry and never stalls. When an entry is taken back, it is presented on the prediction output for one cycle. An occupancy count shows how many entries are held. Misprediction recovery, computing the real jump target and compressed instructions are handled elsewhere.

Top module: `ras_link_predictor`

## Requirements
- R1: Only register numbers 1 and 5 act as link hints. Register numbers such as 0, 2, 4 or 6 in the rd field (bits 11:7) or the rs1 field (bits 19:15) give no hint.
- R2: A JAL (opcode bits 6:0 = 7'b1101111) whose rd is a link register saves PC+4, and occupancy rises by one. With any other rd, the stack is unchanged.
- R3: A JALR (opcode 7'b1100111, funct3 bits 14:12 = 0) whose rd and rs1 are different link registers does two things in one step. It presents the top entry as the prediction and overwrites that same slot with PC+4, so occupancy is unchanged. On an empty stack it gives no prediction and saves PC+4.
- R4: A JALR whose rd and rs1 are the same link register only saves PC+4. It gives no prediction.
- R5: A JALR whose rd is a link register and whose rs1 is not only saves PC+4.
- R6: A JALR whose rs1 is a link register and whose rd is not takes the top entry. That entry appears on pred_target with pred_valid high, and occupancy drops by one.
- R7: A JALR with no link register in rd or rs1 leaves the stack unchanged.
- R8: Some inputs cause no action: any other opcode, a JALR with funct3 not equal to 0, and any cycle with in_valid low.
- R9: The stack holds DEPTH (8) entries. A save on a full stack replaces the oldest entry, and occupancy stays at 8. Later removals return the newest 8 in reverse order.
- R10: A removal on an empty stack keeps pred_valid low, and occupancy stays at 0.
- R11: After reset, occupancy is 0, pred_valid is 0 and pred_target is 0.
- R12: Outputs update in the cycle after the instruction is accepted. pred_valid is high for exactly that one cycle, and only after a removal that found an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The instruction word and PC are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| pred_valid | output | 1 | pred_target holds a predicted return address |
| pred_target | output | 32 | Predicted return address |
| occupancy | output | 4 | Number of entries held (0 to 8) |

## Verification
The bench steers into the hint table's tricky pairings. With rd and rs1 as different link registers, a design that fails to rewrite the top slot in place would leave occupancy off by one. With rd and rs1 as the same link register, a design that wrongly takes an entry first would raise a false prediction. Near-miss register numbers and a JALR with nonzero funct3 catch decoders that look at too few bits. The bench also overfills the ring and drains it past empty. A bad wrap would return stale addresses in the wrong order, and an unguarded removal would report a prediction or wrap the count below zero.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PUSH    = 2'd1,
        ACT_POP     = 2'd2,
        ACT_POPPUSH = 2'd3
    } ras_act_e;

    localparam logic [6:0] OPC_JAL  = 7'b1101111;
    localparam logic [6:0] OPC_JALR = 7'b1100111;
    localparam logic [4:0] LINK_A   = 5'd1;
    localparam logic [4:0] LINK_B   = 5'd5;

    function automatic logic is_link(input logic [4:0] r);
        return (r == LINK_A) || (r == LINK_B);
    endfunction
endpackage

// File: rtl/ras_hint_decode.sv
module ras_hint_decode
    import ras_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output ras_act_e    act_o
);
    logic [6:0] opc;
    logic [4:0] rd_f;
    logic [4:0] rs1_f;
    logic [2:0] f3;
    logic       rd_lnk;
    logic       rs1_lnk;
    logic       unused_imm;

    assign opc        = instr_i[6:0];
    assign rd_f       = instr_i[11:7];
    assign f3         = instr_i[14:12];
    assign rs1_f      = instr_i[19:15];
    assign unused_imm = ^instr_i[31:20];
    assign rd_lnk     = is_link(rd_f);
    assign rs1_lnk    = is_link(rs1_f);

    always_comb begin
        act_o = ACT_NONE;
        if (valid_i) begin
            if (opc == OPC_JAL) begin
                act_o = rd_lnk ? ACT_PUSH : ACT_NONE;
            end else if (opc == OPC_JALR && f3 == 3'b000) begin
                unique case ({rd_lnk, rs1_lnk})
                    2'b11:   act_o = (rd_f == rs1_f) ? ACT_PUSH : ACT_POPPUSH;
                    2'b10:   act_o = ACT_PUSH;
                    2'b01:   act_o = ACT_POP;
                    default: act_o = ACT_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ras_ring.sv
module ras_ring
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  ras_act_e                     act_i,
    input  logic [XLEN-1:0]              push_val_i,
    output logic                         pred_valid_o,
    output logic [XLEN-1:0]              pred_target_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] slot;
        logic [PTR_W-1:0]           wp;
        logic [CNT_W-1:0]           cnt;
        logic                       pv;
        logic [XLEN-1:0]            tgt;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wp_inc;
    logic             have;
    logic             want_pop;
    logic             want_push;

    assign top_idx   = (st_q.wp == '0) ? LAST_IDX : st_q.wp - 1'b1;
    assign wp_inc    = (st_q.wp == LAST_IDX) ? '0 : st_q.wp + 1'b1;
    assign have      = (st_q.cnt != '0);
    assign want_pop  = (act_i == ACT_POP) || (act_i == ACT_POPPUSH);
    assign want_push = (act_i == ACT_PUSH) || (act_i == ACT_POPPUSH);

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        if (act_i == ACT_POPPUSH && have) begin
            st_d.pv            = 1'b1;
            st_d.tgt           = st_q.slot[top_idx];
            st_d.slot[top_idx] = push_val_i;
        end else begin
            if (want_pop && have) begin
                st_d.pv  = 1'b1;
                st_d.tgt = st_q.slot[top_idx];
                st_d.wp  = top_idx;
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (want_push) begin
                st_d.slot[st_q.wp] = push_val_i;
                st_d.wp            = wp_inc;
                if (st_q.cnt != FULL_CNT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid_o  = st_q.pv;
    assign pred_target_o = st_q.tgt;
    assign count_o       = st_q.cnt;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    assert_full_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_PUSH && st_q.cnt == FULL_CNT) |=> (st_q.cnt == FULL_CNT));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_POP && st_q.cnt == '0) |=> (!st_q.pv && st_q.cnt == '0));

    assert_poppush_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_POPPUSH && st_q.cnt != '0) |=> (st_q.pv && $stable(st_q.cnt)));

    assert_pop_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_POP && st_q.cnt != '0) |=>
            (st_q.pv && st_q.cnt == CNT_W'($past(st_q.cnt) - 1'b1)));

    assert_pv_after_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pv |-> $past(want_pop));
endmodule

// File: rtl/ras_link_predictor.sv
module ras_link_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [31:0]                in_instr,
    input  logic [XLEN-1:0]            in_pc,
    output logic                       pred_valid,
    output logic [XLEN-1:0]            pred_target,
    output logic [$clog2(DEPTH+1)-1:0] occupancy
);
    ras_act_e        act;
    logic [XLEN-1:0] ret_addr;

    assign ret_addr = in_pc + XLEN'(4);

    ras_hint_decode u_decode (
        .valid_i (in_valid),
        .instr_i (in_instr),
        .act_o   (act)
    );

    ras_ring #(
        .DEPTH (DEPTH),
        .XLEN  (XLEN)
    ) u_ring (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_i         (act),
        .push_val_i    (ret_addr),
        .pred_valid_o  (pred_valid),
        .pred_target_o (pred_target),
        .count_o       (occupancy)
    );

    assert_other_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[6:0] != OPC_JAL && in_instr[6:0] != OPC_JALR)
            |=> ($stable(occupancy) && !pred_valid));

    assert_idle_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(occupancy) && !pred_valid));
endmodule

// File: tb/sim_ras_link_predictor.sv
module sim_ras_link_predictor;
    localparam int A_NONE = 0, A_PUSH = 1, A_POP = 2, A_PP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic        pred_valid;
    logic [31:0] pred_target;
    logic [3:0]  occupancy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] mq[$];

    always #4 clk = ~clk;

    ras_link_predictor u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_pc(in_pc), .pred_valid(pred_valid), .pred_target(pred_target),
        .occupancy(occupancy)
    );

    function automatic logic [31:0] enc_jal(input logic [4:0] rd);
        return {20'h00010, rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                            input logic [2:0] f3);
        return {12'h000, rs1, f3, rd, 7'b1100111};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [31:0] ins, input logic [31:0] pc,
                         input int act, input logic vld);
        logic        epv;
        logic [31:0] etgt;
        epv  = 1'b0;
        etgt = '0;
        @(negedge clk);
        in_valid = vld;
        in_instr = ins;
        in_pc    = pc;
        @(negedge clk);
        in_valid = 1'b0;
        case (act)
            A_PUSH: begin
                mq.push_back(pc + 32'd4);
                if (mq.size() > 8) void'(mq.pop_front());
            end
            A_POP: if (mq.size() > 0) begin
                epv = 1'b1; etgt = mq.pop_back();
            end
            A_PP: if (mq.size() > 0) begin
                epv = 1'b1; etgt = mq[mq.size()-1]; mq[mq.size()-1] = pc + 32'd4;
            end else begin
                mq.push_back(pc + 32'd4);
            end
            default: ;
        endcase
        chk(req, "pred_valid", {31'b0, pred_valid}, {31'b0, epv});
        if (epv) chk(req, "pred_target", pred_target, etgt);
        chk(req, "occupancy", {28'b0, occupancy}, mq.size());
    endtask

    task automatic t_reset;
        chk("R11", "occupancy", {28'b0, occupancy}, 0);
        chk("R11", "pred_valid", {31'b0, pred_valid}, 0);
        chk("R11", "pred_target", pred_target, 0);
    endtask

    task automatic t_jal;
        issue("R2", enc_jal(5'd1), 32'h100, A_PUSH, 1'b1);
        issue("R2", enc_jal(5'd5), 32'h200, A_PUSH, 1'b1);
        issue("R2", enc_jal(5'd0), 32'h300, A_NONE, 1'b1);
        issue("R1", enc_jal(5'd4), 32'h310, A_NONE, 1'b1);
        issue("R1", enc_jal(5'd6), 32'h320, A_NONE, 1'b1);
    endtask

    task automatic t_pop;
        issue("R6", enc_jalr(5'd0, 5'd5, 3'b000), 32'h400, A_POP, 1'b1);
        @(negedge clk);
        chk("R12", "pred_valid idle", {31'b0, pred_valid}, 0);
    endtask

    task automatic t_poppush;
        issue("R4", enc_jalr(5'd1, 5'd1, 3'b000), 32'h500, A_PUSH, 1'b1);
        issue("R4", enc_jalr(5'd5, 5'd5, 3'b000), 32'h510, A_PUSH, 1'b1);
        issue("R3", enc_jalr(5'd1, 5'd5, 3'b000), 32'h520, A_PP, 1'b1);
        issue("R3", enc_jalr(5'd5, 5'd1, 3'b000), 32'h530, A_PP, 1'b1);
        issue("R3", enc_jalr(5'd0, 5'd1, 3'b000), 32'h540, A_POP, 1'b1);
    endtask

    task automatic t_rd_only_none;
        issue("R5", enc_jalr(5'd1, 5'd7, 3'b000), 32'h600, A_PUSH, 1'b1);
        issue("R5", enc_jalr(5'd5, 5'd0, 3'b000), 32'h610, A_PUSH, 1'b1);
        issue("R7", enc_jalr(5'd3, 5'd4, 3'b000), 32'h620, A_NONE, 1'b1);
        issue("R1", enc_jalr(5'd6, 5'd2, 3'b000), 32'h630, A_NONE, 1'b1);
    endtask

    task automatic t_other;
        issue("R8", {12'h000, 5'd1, 3'b001, 5'd5, 7'b1100111}, 32'h700, A_NONE, 1'b1);
        issue("R8", {12'h000, 5'd1, 3'b000, 5'd5, 7'b1100011}, 32'h710, A_NONE, 1'b1);
        issue("R8", {12'h000, 5'd5, 3'b000, 5'd1, 7'b0010011}, 32'h720, A_NONE, 1'b1);
        issue("R8", enc_jal(5'd1), 32'h730, A_NONE, 1'b0);
        issue("R8", enc_jalr(5'd0, 5'd1, 3'b000), 32'h740, A_NONE, 1'b0);
    endtask

    task automatic t_full_empty;
        while (mq.size() > 0) issue("R6", enc_jalr(5'd0, 5'd1, 3'b000), 32'h800, A_POP, 1'b1);
        for (int i = 0; i < 10; i++)
            issue("R9", enc_jal(5'd1), 32'h1000 + 32'(i * 16), A_PUSH, 1'b1);
        chk("R9", "occupancy full", {28'b0, occupancy}, 8);
        for (int i = 0; i < 8; i++)
            issue("R9", enc_jalr(5'd0, 5'd5, 3'b000), 32'h900, A_POP, 1'b1);
        issue("R10", enc_jalr(5'd0, 5'd5, 3'b000), 32'h910, A_POP, 1'b1);
        issue("R10", enc_jalr(5'd0, 5'd1, 3'b000), 32'h920, A_POP, 1'b1);
        issue("R3", enc_jalr(5'd5, 5'd1, 3'b000), 32'h930, A_PP, 1'b1);
        issue("R3", enc_jalr(5'd0, 5'd1, 3'b000), 32'h940, A_POP, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jal();
        t_pop();
        t_poppush();
        t_rd_only_none();
        t_other();
        t_full_empty();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule